// File: doc/BRIEF.md
# Registered Eight-Bit Arithmetic and Logic Unit

This block performs one arithmetic, bitwise or shift operation on two 8-bit operands each time it is asked to, and holds the outcome in registers. The requester places the operands and a 3-bit operation code on the inputs and raises `go` for one cycle. On the next rising edge the block captures the outcome together with four status flags and raises `ready` for that one cycle.

The outcome and flags keep their values until the next request. Requests may arrive on consecutive cycles, and each one yields its own result one cycle later. The reset is synchronous and active high.

Top module: `alu_reg8`

## Requirements
- R1: Operation codes: 000 gives opd_a+opd_b, 001 gives opd_a-opd_b, 010 gives bitwise AND, 011 gives bitwise OR, 100 gives bitwise XOR, and 101 gives the bitwise inverse of opd_a. Each result is the low 8 bits.
- R2: Code 110 shifts opd_a left by one bit and code 111 shifts it right by one bit. Both shifts are logical, and the bit left empty is 0.
- R3: The operands and code are sampled on the rising edge where `go` is 1. `res` and `flg` show that operation's outcome after that edge, and `ready` is 1 in the same cycle.
- R4: `ready` is 1 for exactly one cycle per `go`. A `go` on every cycle gives a `ready` on every cycle, each carrying the result of the previous cycle's request.
- R5: `flg` is packed {carry, zero, negative, overflow}, with carry at bit 3 and overflow at bit 0. Zero is 1 when the 8-bit result is 0. Negative is bit 7 of the result.
- R6: Carry is bit 8 of the 9-bit add. For subtract it is bit 8 of the 9-bit difference, which is the borrow (1 when opd_a < opd_b unsigned).
- R7: Overflow for add is 1 when both operands share a sign and the result's sign differs. For subtract it is 1 when the operand signs differ and the result's sign differs from opd_a.
- R8: Carry and overflow are 0 for codes 010 through 111.
- R9: When `go` is 0, `res` and `flg` keep their previous values. Changing the operand inputs while `go` is 0 has no effect on them.
- R10: A synchronous reset sets `res` to 0, sets `flg` to 0 and sets `ready` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Request strobe; samples the operands and code |
| opd_a | input | 8 | First operand |
| opd_b | input | 8 | Second operand |
| op_code | input | 3 | Operation select |
| res | output | 8 | Registered result |
| flg | output | 4 | Registered flags {carry, zero, negative, overflow} |
| ready | output | 1 | One-cycle pulse when res and flg are updated |

## Verification
The embedded assertions check the timing contract on every cycle:
- `ready` follows `go` by exactly one cycle.
- The outputs stay stable when there is no request.
- The zero and negative flags agree with the registered result.
- Carry and overflow are clear after non-arithmetic operations.
- Reset clears the outputs.

Only the bench's scenarios can show the values themselves: the right result for each code, the borrow convention of subtraction, signed overflow at the boundary operands, and the ordering of back-to-back results.

// File: rtl/alu_reg8_pkg.sv
package alu_reg8_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_XOR = 3'b100,
    OP_INV = 3'b101,
    OP_SHL = 3'b110,
    OP_SHR = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic cy;
    logic zr;
    logic ng;
    logic ov;
  } alu_flags_t;
endpackage

// File: rtl/alu_reg8_core.sv
module alu_reg8_core
  import alu_reg8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   code,
  output logic [W-1:0] y,
  output alu_flags_t   f,
  output logic         arith
);
  localparam int MSB = W - 1;

  function automatic logic [W:0] add_ext(input logic [W-1:0] x, input logic [W-1:0] z);
    return {1'b0, x} + {1'b0, z};
  endfunction

  function automatic logic [W:0] sub_ext(input logic [W-1:0] x, input logic [W-1:0] z);
    return {1'b0, x} - {1'b0, z};
  endfunction

  logic [W:0] wide;
  logic       ovf;

  always_comb begin
    wide  = '0;
    ovf   = 1'b0;
    arith = 1'b0;
    unique case (alu_op_e'(code))
      OP_ADD: begin
        wide  = add_ext(a, b);
        ovf   = (a[MSB] == b[MSB]) && (wide[MSB] != a[MSB]);
        arith = 1'b1;
      end
      OP_SUB: begin
        wide  = sub_ext(a, b);
        ovf   = (a[MSB] != b[MSB]) && (wide[MSB] != a[MSB]);
        arith = 1'b1;
      end
      OP_AND: wide[W-1:0] = a & b;
      OP_OR:  wide[W-1:0] = a | b;
      OP_XOR: wide[W-1:0] = a ^ b;
      OP_INV: wide[W-1:0] = ~a;
      OP_SHL: wide[W-1:0] = {a[W-2:0], 1'b0};
      OP_SHR: wide[W-1:0] = {1'b0, a[W-1:1]};
      default: wide = '0;
    endcase
  end

  assign y    = wide[W-1:0];
  assign f.cy = wide[W];
  assign f.zr = (wide[W-1:0] == '0);
  assign f.ng = wide[MSB];
  assign f.ov = ovf;
endmodule

// File: rtl/alu_reg8_out.sv
module alu_reg8_out
  import alu_reg8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         load_arith,
  input  logic [W-1:0] y_in,
  input  alu_flags_t   f_in,
  output logic [W-1:0] y_q,
  output alu_flags_t   f_q,
  output logic         vld_q
);
  logic last_arith;

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q        <= '0;
      f_q        <= '0;
      vld_q      <= 1'b0;
      last_arith <= 1'b0;
    end else begin
      vld_q <= load;
      if (load) begin
        y_q        <= y_in;
        f_q        <= f_in;
        last_arith <= load_arith;
      end
    end
  end

  // R10: reset clears every output on the next edge
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (y_q == '0 && f_q == '0 && !vld_q));
  // R5: zero and negative agree with the registered result
  a_r5_zero_neg: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> (f_q.zr == (y_q == '0)) && (f_q.ng == y_q[W-1]));
  // R8: non-arithmetic results carry no carry or overflow
  a_r8_logic_no_cy_ov: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !last_arith) |-> (!f_q.cy && !f_q.ov));
endmodule

// File: rtl/alu_reg8.sv
module alu_reg8
  import alu_reg8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] opd_a,
  input  logic [W-1:0] opd_b,
  input  logic [2:0]   op_code,
  output logic [W-1:0] res,
  output logic [3:0]   flg,
  output logic         ready
);
  logic [W-1:0] core_y;
  alu_flags_t   core_f;
  logic         core_arith;
  alu_flags_t   flags_q;

  alu_reg8_core #(.W(W)) u_core (
    .a(opd_a), .b(opd_b), .code(op_code),
    .y(core_y), .f(core_f), .arith(core_arith)
  );

  alu_reg8_out #(.W(W)) u_out (
    .clk(clk), .rst(rst), .load(go), .load_arith(core_arith),
    .y_in(core_y), .f_in(core_f),
    .y_q(res), .f_q(flags_q), .vld_q(ready)
  );

  assign flg = flags_q;

  // R3: ready follows a request by one cycle
  a_r3_ready_after_go: assert property (@(posedge clk) disable iff (rst)
    go |=> ready);
  // R4: no ready without a request the cycle before
  a_r4_ready_needs_go: assert property (@(posedge clk) disable iff (rst)
    !go |=> !ready);
  // R9: outputs hold when there is no request
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!go && !$past(rst)) |=> ($stable(res) && $stable(flg)));
endmodule

// File: tb/alu_reg8_bench.sv
module alu_reg8_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       go = 1'b0;
  logic [7:0] opd_a = '0, opd_b = '0;
  logic [2:0] op_code = '0;
  logic [7:0] res;
  logic [3:0] flg;
  logic       ready;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  alu_reg8 u_alu_reg8 (
    .clk(clk), .rst(rst), .go(go), .opd_a(opd_a), .opd_b(opd_b),
    .op_code(op_code), .res(res), .flg(flg), .ready(ready)
  );

  // {code, a, b, expected result, expected flags {c,z,n,v}}
  localparam int NV = 20;
  localparam logic [30:0] VEC [NV] = '{
    {3'd0, 8'h03, 8'h05, 8'h08, 4'b0000},
    {3'd0, 8'hFF, 8'h01, 8'h00, 4'b1100},
    {3'd0, 8'h7F, 8'h01, 8'h80, 4'b0011},
    {3'd0, 8'h80, 8'h80, 8'h00, 4'b1101},
    {3'd1, 8'h05, 8'h03, 8'h02, 4'b0000},
    {3'd1, 8'h03, 8'h05, 8'hFE, 4'b1010},
    {3'd1, 8'h80, 8'h01, 8'h7F, 4'b0001},
    {3'd1, 8'h7F, 8'hFF, 8'h80, 4'b1011},
    {3'd1, 8'h42, 8'h42, 8'h00, 4'b0100},
    {3'd2, 8'hF0, 8'h3C, 8'h30, 4'b0000},
    {3'd2, 8'h0F, 8'hF0, 8'h00, 4'b0100},
    {3'd3, 8'h81, 8'h02, 8'h83, 4'b0010},
    {3'd4, 8'hAA, 8'hFF, 8'h55, 4'b0000},
    {3'd4, 8'h5A, 8'h5A, 8'h00, 4'b0100},
    {3'd5, 8'h00, 8'h12, 8'hFF, 4'b0010},
    {3'd5, 8'hFF, 8'h00, 8'h00, 4'b0100},
    {3'd6, 8'hC1, 8'h00, 8'h82, 4'b0010},
    {3'd6, 8'h80, 8'h00, 8'h00, 4'b0100},
    {3'd7, 8'h81, 8'h00, 8'h40, 4'b0000},
    {3'd7, 8'h01, 8'hFF, 8'h00, 4'b0100}
  };

  task automatic check(input string tag, input logic [7:0] r, input logic [3:0] f,
                       input logic rd, input logic [7:0] er, input logic [3:0] ef,
                       input logic erd);
    checks++;
    if (r !== er || f !== ef || rd !== erd) begin
      errors++;
      $display("FAIL %s: res=%h flg=%b ready=%b expected res=%h flg=%b ready=%b",
               tag, r, f, rd, er, ef, erd);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    go = 1'b1; op_code = c; opd_a = a; opd_b = b;
    @(negedge clk);
    go = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset state", res, flg, ready, 8'h00, 4'b0000, 1'b0);

    // R1 R2 R5 R6 R7 R8 via the table
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][30:28], VEC[i][27:20], VEC[i][19:12]);
      check($sformatf("R1/R2/R5-R8 vec%0d", i), res, flg, ready,
            VEC[i][11:4], VEC[i][3:0], 1'b1);
    end

    // R4: single pulse, then R9 hold with operands changing
    @(negedge clk);
    check("R4 ready one cycle", res, flg, ready, 8'h00, 4'b0100, 1'b0);
    opd_a = 8'h11; opd_b = 8'h22; op_code = 3'd0;
    @(negedge clk);
    check("R9 hold while idle", res, flg, ready, 8'h00, 4'b0100, 1'b0);

    // R3 R4 back-to-back
    @(negedge clk);
    go = 1'b1; op_code = 3'd0; opd_a = 8'h10; opd_b = 8'h20;
    @(negedge clk);
    check("R3 back-to-back first", res, flg, ready, 8'h30, 4'b0000, 1'b1);
    op_code = 3'd1; opd_a = 8'h01; opd_b = 8'h02;
    @(negedge clk);
    check("R4 back-to-back second", res, flg, ready, 8'hFF, 4'b1010, 1'b1);
    op_code = 3'd2; opd_a = 8'hFF; opd_b = 8'h0F;
    @(negedge clk);
    go = 1'b0;
    check("R4 back-to-back third", res, flg, ready, 8'h0F, 4'b0000, 1'b1);
    @(negedge clk);
    check("R4 ready drops", res, flg, ready, 8'h0F, 4'b0000, 1'b0);

    // R10 reset mid-stream after a flagged result
    issue(3'd0, 8'hFF, 8'hFF);
    check("R6 carry before reset", res, flg, ready, 8'hFE, 4'b1010, 1'b1);
    rst = 1'b1; go = 1'b1;
    @(negedge clk);
    rst = 1'b0; go = 1'b0;
    check("R10 reset clears", res, flg, ready, 8'h00, 4'b0000, 1'b0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule